// File: doc/BRIEF.md
# Keyed Write Lock Filter for a Byte-Wide Nonvolatile Store

This block sits between the write-cycle latches of a byte-wide nonvolatile memory and the sequencer that programs the array. Each latched write arrives as one `wr_vld` cycle carrying a 17-bit address and a data byte. The block answers one cycle later with `wr_ok`, which tells the sequencer whether to commit that byte or drop it. It also keeps a lock flag that survives the reset pin, so the flag behaves like a nonvolatile bit.

Two keyed strings of writes change the lock. A three-write opening key grants access. When real data follows the key, the lock is switched on, or stays on, and every write of the current page load is committed. A six-write release string switches the lock off. None of the release bytes past the second one ever reaches the array. While the lock is on, a write with no key in front of it is dropped. A write that does not fit the string in progress abandons the string and is judged as an ordinary write.

Top module: `wrlock_guard`

## Requirements
- R1: After power-up the lock flag `prot_on` is 0, and any write is committed: `wr_ok` is 1 in the cycle after the `wr_vld` cycle.
- R2: The opening key alone leaves `prot_on` unchanged. The key is data 0xAA at address 0x05555, then 0x55 at 0x02AAA or 0x0AAAA, then 0xA0 at 0x05555. "Alone" means the key is followed by `page_end` with no data write.
- R3: A write that follows a complete opening key is committed, and it sets `prot_on` to 1 from the cycle after that write.
- R4: While `prot_on` is 1, a write with no opening key in front of it gives `wr_ok` = 0.
- R5: Once the opening key has been given, every write is committed until `page_end` is seen. `page_end` is sampled in the same cycle as any write, and the write is processed first. After `page_end`, an unkeyed write is dropped again while `prot_on` stays 1.
- R6: The release string sets `prot_on` to 0 in the cycle after its sixth write. The string is 0xAA at 0x05555, 0x55 at 0x02AAA or 0x0AAAA, 0x80 at 0x05555, 0xAA at 0x05555, 0x55 at 0x02AAA or 0x0AAAA, then 0x20 at 0x05555. Writes three to six always give `wr_ok` = 0. Writes one and two are judged like ordinary writes.
- R7: A write that does not match the next step of a partial string abandons that string and is judged against the current lock flag. If that write is 0xAA at 0x05555, it starts a new string.
- R8: Key addresses are compared on all 17 bits. For example, 0xAA at 0x15555 does not begin a key.
- R9: While `rst_n` is low, `wr_ok` stays 0 and any partial string or open grant is discarded. `prot_on` keeps its value across reset.
- R10: `wr_ok` is 1 only in a cycle directly after a `wr_vld` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin; clears the matcher, not the lock flag |
| wr_vld | input | 1 | One latched write cycle is presented |
| wr_addr | input | 17 | Address of the write |
| wr_data | input | 8 | Data byte of the write |
| page_end | input | 1 | The current page load has closed |
| wr_ok | output | 1 | Commit decision for the previous cycle's write |
| prot_on | output | 1 | Lock flag |

## Verification
The hardest cases are broken strings that leave the matcher one step short of a key. Examples are a lead byte repeated in the middle of a string, a release string cut at its last step, and a grant still open when reset arrives. These states cannot be reached through the ports except by exact sequences of writes. A directed part of the bench drives each of them on purpose. After that, a long pseudo-random run weights its choices toward full keys, full release strings, strings with one step corrupted, aliased addresses, page closes and resets. A reference model in the bench predicts every decision in that run.

// File: rtl/wrlock_pkg.sv
package wrlock_pkg;

    // Matcher position; the order is the sequence the keys are walked in
    typedef enum logic [2:0] {
        M_IDLE  = 3'd0,
        M_K1    = 3'd1,
        M_K2    = 3'd2,
        M_OPEN  = 3'd3,
        M_D3    = 3'd4,
        M_D4    = 3'd5,
        M_D5    = 3'd6
    } mode_e;

    // Classification of one write against the key steps
    typedef struct packed {
        logic lead;      // first byte of either string
        logic second;    // second byte of either string
        logic unlock;    // third byte of the opening key
        logic erase_go;  // third byte of the release string
        logic release_b; // last byte of the release string
    } key_t;

    typedef struct packed {
        mode_e mode;
        logic  ok;
    } regs_t;

endpackage

// File: rtl/wrlock_key_decode.sv
module wrlock_key_decode
    import wrlock_pkg::*;
#(
    parameter int                        ADDR_W    = 17,
    parameter int                        DATA_W    = 8,
    parameter int                        NUM_ALT   = 2,
    parameter logic [ADDR_W-1:0]         MAIN_ADDR = 17'h05555,
    parameter logic [NUM_ALT*ADDR_W-1:0] ALT_ADDRS = {17'h0AAAA, 17'h02AAA},
    parameter logic [DATA_W-1:0]         B_LEAD    = 8'hAA,
    parameter logic [DATA_W-1:0]         B_SECOND  = 8'h55,
    parameter logic [DATA_W-1:0]         B_UNLOCK  = 8'hA0,
    parameter logic [DATA_W-1:0]         B_ERASE   = 8'h80,
    parameter logic [DATA_W-1:0]         B_RELEASE = 8'h20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output key_t              key
);

    logic [NUM_ALT-1:0] alt_hit;
    logic               main_hit;
    logic               any_alt;

    // One full-width comparator per alternate second-step address
    for (genvar g = 0; g < NUM_ALT; g++) begin : g_alt
        assign alt_hit[g] = (addr == ALT_ADDRS[g*ADDR_W +: ADDR_W]);
    end

    assign main_hit = (addr == MAIN_ADDR);
    assign any_alt  = |alt_hit;

    always_comb begin
        key.lead      = main_hit && (data == B_LEAD);
        key.second    = any_alt  && (data == B_SECOND);
        key.unlock    = main_hit && (data == B_UNLOCK);
        key.erase_go  = main_hit && (data == B_ERASE);
        key.release_b = main_hit && (data == B_RELEASE);
    end

endmodule

// File: rtl/wrlock_step_next.sv
module wrlock_step_next
    import wrlock_pkg::*;
(
    input  mode_e mode,
    input  key_t  key,
    input  logic  wr_vld,
    input  logic  page_end,
    input  logic  prot,
    output mode_e mode_nxt,
    output logic  commit,
    output logic  set_prot,
    output logic  clr_prot
);

    logic brk;

    always_comb begin
        mode_nxt = mode;
        commit   = 1'b0;
        set_prot = 1'b0;
        clr_prot = 1'b0;
        brk      = 1'b0;

        if (wr_vld) begin
            case (mode)
                M_OPEN: begin
                    // Granted page: data lands and the lock engages
                    commit   = 1'b1;
                    set_prot = 1'b1;
                end
                M_K1: begin
                    if (key.second) begin
                        mode_nxt = M_K2;
                        commit   = !prot;
                    end else begin
                        brk = 1'b1;
                    end
                end
                M_K2: begin
                    if (key.unlock) begin
                        mode_nxt = M_OPEN;
                        commit   = !prot;
                    end else if (key.erase_go) begin
                        mode_nxt = M_D3;
                    end else begin
                        brk = 1'b1;
                    end
                end
                M_D3: begin
                    if (key.lead) mode_nxt = M_D4;
                    else          brk      = 1'b1;
                end
                M_D4: begin
                    if (key.second) mode_nxt = M_D5;
                    else            brk      = 1'b1;
                end
                M_D5: begin
                    if (key.release_b) begin
                        mode_nxt = M_IDLE;
                        clr_prot = 1'b1;
                    end else begin
                        brk = 1'b1;
                    end
                end
                default: brk = 1'b1;
            endcase

            // Ordinary write, or one that abandons a partial string
            if (brk) begin
                commit   = !prot;
                mode_nxt = key.lead ? M_K1 : M_IDLE;
            end
        end

        // Page close ends a grant, after this cycle's write is handled
        if (page_end && (mode_nxt == M_OPEN)) begin
            mode_nxt = M_IDLE;
        end
    end

endmodule

// File: rtl/wrlock_guard.sv
module wrlock_guard
    import wrlock_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              page_end,
    output logic              wr_ok,
    output logic              prot_on
);

    localparam regs_t REGS_RST = '{mode: M_IDLE, ok: 1'b0};

    regs_t state_d, state_q;
    logic  prot_d;
    logic  prot_q = 1'b0;  // as-delivered value; not touched by rst_n

    key_t  key;
    mode_e mode_nxt;
    logic  commit, set_prot, clr_prot;

    wrlock_key_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .addr (wr_addr),
        .data (wr_data),
        .key  (key)
    );

    wrlock_step_next u_next (
        .mode     (state_q.mode),
        .key      (key),
        .wr_vld   (wr_vld),
        .page_end (page_end),
        .prot     (prot_q),
        .mode_nxt (mode_nxt),
        .commit   (commit),
        .set_prot (set_prot),
        .clr_prot (clr_prot)
    );

    always_comb begin
        state_d      = state_q;
        state_d.mode = mode_nxt;
        state_d.ok   = commit;
        prot_d       = prot_q;
        if (rst_n) begin
            if (set_prot)      prot_d = 1'b1;
            else if (clr_prot) prot_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REGS_RST;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        prot_q <= prot_d;
    end

    assign wr_ok   = state_q.ok;
    assign prot_on = prot_q;

endmodule

// File: rtl/wrlock_guard_chk.sv
module wrlock_guard_chk
    import wrlock_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_vld,
    input logic [16:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic        wr_ok,
    input logic        prot_on,
    input mode_e       mode
);

    // R10: a commit needs a write in the cycle before
    a_r10_ok_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> $past(wr_vld));

    // R4: locked and no key in progress -> the write is dropped
    a_r4_locked_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_on && mode == M_IDLE && wr_vld) |=> !wr_ok);

    // R3: the lock only engages on a write inside an open grant
    a_r3_engage_on_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(mode == M_OPEN && wr_vld));

    // R6: last release byte clears the lock and is not committed
    a_r6_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_D5 && wr_vld && wr_addr == 17'h05555 && wr_data == 8'h20)
        |=> (!prot_on && !wr_ok));

    // R9: no commit during reset, lock flag frozen while reset is held
    a_r9_no_commit_in_reset: assert property (@(posedge clk)
        !rst_n |-> !wr_ok);
    a_r9_lock_frozen: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> $stable(prot_on));

endmodule

bind wrlock_guard wrlock_guard_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_vld  (wr_vld),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_ok   (wr_ok),
    .prot_on (prot_on),
    .mode    (state_q.mode)
);

// File: tb/test_wrlock_guard.sv
module test_wrlock_guard;

    localparam int CLK_PERIOD = 10;
    localparam logic [16:0] A_M  = 17'h05555;
    localparam logic [16:0] A_B  = 17'h02AAA;
    localparam logic [16:0] A_C  = 17'h0AAAA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_vld = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        page_end = 1'b0;
    logic        wr_ok;
    logic        prot_on;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model: 0 idle,1 k1,2 k2,3 open,4 d3,5 d4,6 d5
    int m_st   = 0;
    bit m_prot = 1'b0;
    bit m_ok   = 1'b0;
    logic [31:0] rng = 32'h1234_5679;

    always #(CLK_PERIOD/2) clk = ~clk;

    wrlock_guard i_wrlock_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_vld   (wr_vld),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .page_end (page_end),
        .wr_ok    (wr_ok),
        .prot_on  (prot_on)
    );

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model(input bit v, input logic [16:0] a, input logic [7:0] d, input bit pe);
        bit lead, sec, unl, ers, rel, brk;
        lead = (a == A_M) && (d == 8'hAA);
        sec  = (a == A_B || a == A_C) && (d == 8'h55);
        unl  = (a == A_M) && (d == 8'hA0);
        ers  = (a == A_M) && (d == 8'h80);
        rel  = (a == A_M) && (d == 8'h20);
        m_ok = 1'b0;
        if (!rst_n) begin
            m_st = 0;
            return;
        end
        brk = 1'b0;
        if (v) begin
            case (m_st)
                3: begin m_ok = 1'b1; m_prot = 1'b1; end
                1: if (sec) begin m_st = 2; m_ok = !m_prot; end else brk = 1'b1;
                2: if (unl) begin m_st = 3; m_ok = !m_prot; end
                   else if (ers) m_st = 4; else brk = 1'b1;
                4: if (lead) m_st = 5; else brk = 1'b1;
                5: if (sec) m_st = 6; else brk = 1'b1;
                6: if (rel) begin m_st = 0; m_prot = 1'b0; end else brk = 1'b1;
                default: brk = 1'b1;
            endcase
            if (brk) begin
                m_ok = !m_prot;
                m_st = lead ? 1 : 0;
            end
        end
        if (pe && m_st == 3) m_st = 0;
    endtask

    // one cycle of stimulus, then compare both outputs against the model
    task automatic step(input bit v, input logic [16:0] a, input logic [7:0] d,
                        input bit pe, input string tag);
        @(negedge clk);
        wr_vld = v; wr_addr = a; wr_data = d; page_end = pe;
        @(negedge clk);
        model(v, a, d, pe);
        wr_vld = 1'b0; page_end = 1'b0;
        check(tag, wr_ok, m_ok, "wr_ok");
        check(tag, prot_on, m_prot, "prot_on");
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d, input string tag);
        step(1'b1, a, d, 1'b0, tag);
    endtask

    task automatic opening(input logic [16:0] alt, input string tag);
        wr(A_M, 8'hAA, tag);
        wr(alt, 8'h55, tag);
        wr(A_M, 8'hA0, tag);
    endtask

    task automatic release_seq(input int bad_step, input string tag);
        logic [16:0] a [6];
        logic [7:0]  d [6];
        a = '{A_M, A_B, A_M, A_M, A_C, A_M};
        d = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
        for (int i = 0; i < 6; i++) begin
            if (i == bad_step) wr(a[i] ^ 17'h10000, d[i], tag);
            else               wr(a[i], d[i], tag);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [16:0] alist [6];
        logic [7:0]  dlist [6];
        alist = '{A_M, A_B, A_C, 17'h15555, 17'h12AAA, 17'h00123};
        dlist = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h20, 8'h3C};

        repeat (3) @(negedge clk);
        check("R1", prot_on, 1'b0, "prot_on at power-up");
        check("R9", wr_ok, 1'b0, "wr_ok in reset");
        rst_n = 1'b1;

        // R1: unlocked, plain write commits
        wr(17'h00100, 8'h11, "R1");
        check("R1", wr_ok, 1'b1, "literal commit");
        // R10: an idle cycle gives no commit
        step(1'b0, 17'h00100, 8'h11, 1'b0, "R10");
        // R2: key alone, then page close: lock stays off
        opening(A_B, "R2");
        step(1'b0, 17'h0, 8'h0, 1'b1, "R2");
        check("R2", prot_on, 1'b0, "literal lock after bare key");
        // R3: key plus data engages lock
        opening(A_C, "R3");
        wr(17'h00200, 8'h22, "R3");
        check("R3", prot_on, 1'b1, "literal lock after key+data");
        // R5: more writes in the same page still commit, then page close
        wr(17'h00201, 8'h23, "R5");
        step(1'b1, 17'h00202, 8'h24, 1'b1, "R5");
        // R4: locked, unkeyed write dropped
        wr(17'h00300, 8'h33, "R4");
        check("R4", wr_ok, 1'b0, "literal drop");
        // R7: break a partial key, then restart with a lead in mid-string
        wr(A_M, 8'hAA, "R7");
        wr(17'h00400, 8'h44, "R7");
        wr(A_M, 8'hAA, "R7");
        wr(A_B, 8'h55, "R7");
        wr(A_M, 8'hAA, "R7");
        opening(A_B, "R7");
        wr(17'h00401, 8'h45, "R7");
        step(1'b0, 17'h0, 8'h0, 1'b1, "R7");
        // R8: aliased key address does not unlock
        wr(17'h15555, 8'hAA, "R8");
        wr(A_B, 8'h55, "R8");
        wr(A_M, 8'hA0, "R8");
        wr(17'h00500, 8'h55, "R8");
        check("R8", wr_ok, 1'b0, "aliased key");
        // R9: open grant killed by reset, lock flag survives
        opening(A_B, "R9");
        @(negedge clk); rst_n = 1'b0;
        step(1'b1, 17'h00600, 8'h66, 1'b0, "R9");
        @(negedge clk); rst_n = 1'b1;
        m_st = 0;
        wr(17'h00601, 8'h67, "R9");
        check("R9", prot_on, 1'b1, "lock across reset");
        // R6: release string cut at the last step, then a full one
        release_seq(5, "R6");
        check("R6", prot_on, 1'b1, "lock after cut string");
        release_seq(-1, "R6");
        check("R6", prot_on, 1'b0, "literal lock after release");
        wr(17'h00700, 8'h77, "R6");
        // R6 while unlocked: first two bytes commit, the rest do not
        release_seq(-1, "R6");

        // pseudo-random sweep weighted toward key strings
        for (int it = 0; it < 3000; it++) begin
            rng = nxt(rng);
            case (rng[3:0])
                4'd0, 4'd1: begin
                    opening(rng[4] ? A_B : A_C, "R3");
                    if (rng[5]) wr(alist[rng[8:6] % 6], dlist[rng[11:9] % 6], "R5");
                end
                4'd2: release_seq(rng[6:4] % 8, "R6");
                4'd3: step(1'b0, 17'h0, 8'h0, 1'b1, "R5");
                4'd4: step(1'b0, 17'h0, 8'h0, 1'b0, "R10");
                4'd5: if (rng[7:4] == 4'd0) begin
                    @(negedge clk); rst_n = 1'b0;
                    step(1'b1, A_M, 8'hAA, 1'b0, "R9");
                    @(negedge clk); rst_n = 1'b1;
                    m_st = 0;
                end
                default: step(1'b1, alist[rng[6:4] % 6], dlist[rng[9:7] % 6],
                              rng[10] & rng[11], "R7");
            endcase
        end

        finish_run();
    end

endmodule